// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Selector

This block decides, for each of the two ALU operands in the execute stage of a five-stage in-order pipeline, where the operand should come from. There are three choices. The first is the value read from the register file during decode. The second is the ALU result held by the instruction one stage ahead. The third is the writeback value held by the instruction two stages ahead. The block is purely combinational.

Its inputs are the two source register numbers latched for the instruction now in execute. It also takes the destination register number and the register-write flag of each of the two older instructions. It drives one 2-bit select per operand, and the datapath muxes use those selects directly.

A forward from an older instruction happens only when that instruction really writes a register and its destination is not register zero. If both older instructions target the operand's source register, the younger one wins, because it carries the more recent value. The two operands are decided independently of each other.

Top module: `fwd_select_unit`

## Requirements
- R1: Select encoding on `fwd_a` and `fwd_b`: 2'b00 picks the register-file value, 2'b10 picks the result of the instruction one stage ahead, 2'b01 picks the writeback value two stages ahead, and 2'b11 never appears.
- R2: `fwd_a` is 2'b10 whenever `mem_wr` is 1, `mem_dst` is nonzero and `mem_dst` equals `ex_rs`.
- R3: `fwd_b` is 2'b10 whenever `mem_wr` is 1, `mem_dst` is nonzero and `mem_dst` equals `ex_rt`.
- R4: When R2 (or R3) does not hold for an operand, that operand's select is 2'b01 whenever `wb_wr` is 1, `wb_dst` is nonzero and `wb_dst` equals the operand's source register.
- R5: A destination of register 0 never causes a forward from its stage, even when it matches a source and its write flag is set.
- R6: A stage whose write flag is 0 never causes a forward, even when its destination matches a source.
- R7: When both older stages qualify for the same operand, the select is 2'b10.
- R8: `fwd_a` depends only on `ex_rs` and the stage inputs, and `fwd_b` depends only on `ex_rt` and the stage inputs. Changing one source register never changes the other operand's select.
- R9: With no qualifying match for an operand, including the all-zero input state, its select is 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_rs | input | RW | First source register number of the instruction in execute |
| ex_rt | input | RW | Second source register number of the instruction in execute |
| mem_dst | input | RW | Destination register of the instruction one stage ahead |
| mem_wr | input | 1 | That instruction writes a register |
| wb_dst | input | RW | Destination register of the instruction two stages ahead |
| wb_wr | input | 1 | That instruction writes a register |
| fwd_a | output | 2 | Select for the first ALU operand |
| fwd_b | output | 2 | Select for the second ALU operand |

## Verification
The hardest situation to reach is the one where both older stages name the same nonzero register as an operand's source while both write flags are set, and at the same time the other operand sees a different mix of matches. Random register numbers over a 32-entry space almost never produce this. The stimulus therefore sweeps every combination of source and destination numbers over the four lowest registers, for all four write-flag settings. That small set contains register 0 and every pattern of overlap, so the priority case, the zero-destination case and the disabled-write case each occur many times on each operand. A dependency chain is also replayed, along with random full-width cases and tests that change one source while holding the other.

// File: rtl/fwd_select_unit.sv
module fwd_select_unit #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] ex_rs,
  input  logic [RW-1:0] ex_rt,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_wr,
  input  logic [RW-1:0] wb_dst,
  input  logic          wb_wr,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b
);

  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_WB  = 2'b01;
  localparam logic [1:0] SEL_MEM = 2'b10;

  logic mem_live, wb_live;
  assign mem_live = mem_wr && (mem_dst != '0);
  assign wb_live  = wb_wr  && (wb_dst  != '0);

  logic [RW-1:0] src [2];
  logic [1:0]    sel [2];
  assign src[0] = ex_rs;
  assign src[1] = ex_rt;

  for (genvar i = 0; i < 2; i++) begin : g_opnd
    logic hit_mem, hit_wb;
    assign hit_mem = mem_live && (mem_dst == src[i]);
    assign hit_wb  = wb_live  && (wb_dst  == src[i]);
    assign sel[i]  = hit_mem ? SEL_MEM : (hit_wb ? SEL_WB : SEL_RF);
  end

  assign fwd_a = sel[0];
  assign fwd_b = sel[1];

endmodule

module fwd_select_unit_chk #(
  parameter int RW = 5
) (
  input logic [RW-1:0] ex_rs,
  input logic [RW-1:0] ex_rt,
  input logic [RW-1:0] mem_dst,
  input logic          mem_wr,
  input logic [RW-1:0] wb_dst,
  input logic          wb_wr,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b
);

  logic known;
  assign known = !$isunknown({ex_rs, ex_rt, mem_dst, mem_wr, wb_dst, wb_wr, fwd_a, fwd_b});

  always_comb begin
    if (known) begin
      assert_no_code11_R1: assert (fwd_a != 2'b11 && fwd_b != 2'b11)
        else $error("select 11 seen");
      assert_mem_pick_a_R2: assert (!(mem_wr && mem_dst != '0 && mem_dst == ex_rs) || fwd_a == 2'b10)
        else $error("A missed EX/MEM forward");
      assert_mem_pick_b_R3: assert (!(mem_wr && mem_dst != '0 && mem_dst == ex_rt) || fwd_b == 2'b10)
        else $error("B missed EX/MEM forward");
      assert_wb_pick_a_R4: assert (fwd_a != 2'b01 || (wb_wr && wb_dst != '0 && wb_dst == ex_rs))
        else $error("A forwarded from writeback without cause");
      assert_zero_dst_R5: assert (!(mem_dst == '0 && wb_dst == '0) || (fwd_a == 2'b00 && fwd_b == 2'b00))
        else $error("forward from register zero");
      assert_no_write_R6: assert ((mem_wr || wb_wr) || (fwd_a == 2'b00 && fwd_b == 2'b00))
        else $error("forward without write");
      assert_mem_cause_R7: assert (fwd_b != 2'b10 || (mem_wr && mem_dst != '0 && mem_dst == ex_rt))
        else $error("B picked EX/MEM without cause");
    end
  end

endmodule

bind fwd_select_unit fwd_select_unit_chk #(.RW(RW)) u_chk (.*);

// File: tb/fwd_select_unit_test.sv
`timescale 1ns/1ps
module fwd_select_unit_test;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0] ex_rs, ex_rt, mem_dst, wb_dst;
  logic       mem_wr, wb_wr;
  logic [1:0] fwd_a, fwd_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  fwd_select_unit #(.RW(5)) uut (
    .ex_rs(ex_rs), .ex_rt(ex_rt), .mem_dst(mem_dst), .mem_wr(mem_wr),
    .wb_dst(wb_dst), .wb_wr(wb_wr), .fwd_a(fwd_a), .fwd_b(fwd_b)
  );

  function automatic logic [1:0] ref_sel(logic [4:0] s);
    if (mem_wr && mem_dst != 0 && mem_dst == s) return 2'b10;
    if (wb_wr && wb_dst != 0 && wb_dst == s)    return 2'b01;
    return 2'b00;
  endfunction

  function automatic string tag_for(logic [4:0] s, string mem_tag);
    bit mq = mem_wr && mem_dst != 0 && mem_dst == s;
    bit wq = wb_wr && wb_dst != 0 && wb_dst == s;
    if (mq && wq) return "R7";
    if (mq) return mem_tag;
    if (wq) return "R4";
    if ((mem_wr && mem_dst == 0 && s == 0) || (wb_wr && wb_dst == 0 && s == 0)) return "R5";
    if ((!mem_wr && mem_dst == s) || (!wb_wr && wb_dst == s)) return "R6";
    return "R9";
  endfunction

  task automatic check(string tag, string what, logic [1:0] act, logic [1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b (rs=%0d rt=%0d md=%0d mw=%0b wd=%0d ww=%0b)",
               tag, what, act, exp, ex_rs, ex_rt, mem_dst, mem_wr, wb_dst, wb_wr);
    end
  endtask

  task automatic apply(logic [4:0] rs, logic [4:0] rt, logic [4:0] md, logic mw,
                       logic [4:0] wd, logic ww);
    @(negedge clk);
    ex_rs = rs; ex_rt = rt; mem_dst = md; mem_wr = mw; wb_dst = wd; wb_wr = ww;
    #1;
  endtask

  task automatic check_both();
    check(tag_for(ex_rs, "R2"), "fwd_a", fwd_a, ref_sel(ex_rs));
    check(tag_for(ex_rt, "R3"), "fwd_b", fwd_b, ref_sel(ex_rt));
    n_cmp++;
    if (fwd_a === 2'b11 || fwd_b === 2'b11) begin
      n_bad++;
      $display("FAIL R1 code 11: actual %b/%b expected not 11", fwd_a, fwd_b);
    end
  endtask

  initial begin
    ex_rs = 0; ex_rt = 0; mem_dst = 0; mem_wr = 0; wb_dst = 0; wb_wr = 0;
    apply(0, 0, 0, 0, 0, 0);
    check("R9", "idle fwd_a", fwd_a, 2'b00);
    check("R9", "idle fwd_b", fwd_b, 2'b00);

    // dependency chain: sub $2 / and $12,$2,$5 / or $13,$6,$2 / add $14,$2,$2 / sw $15,($2)
    apply(2, 5, 2, 1, 0, 0);
    check("R2", "chain and A", fwd_a, 2'b10);
    check("R9", "chain and B", fwd_b, 2'b00);
    apply(6, 2, 12, 1, 2, 1);
    check("R9", "chain or A", fwd_a, 2'b00);
    check("R4", "chain or B", fwd_b, 2'b01);
    apply(2, 2, 13, 1, 12, 1);
    check("R9", "chain add A", fwd_a, 2'b00);
    check("R9", "chain add B", fwd_b, 2'b00);
    apply(2, 15, 14, 1, 13, 1);
    check("R9", "chain sw A", fwd_a, 2'b00);
    check("R9", "chain sw B", fwd_b, 2'b00);

    // directed corners with wide register numbers
    apply(31, 31, 31, 1, 31, 1);
    check("R7", "both stages A", fwd_a, 2'b10);
    check("R7", "both stages B", fwd_b, 2'b10);
    apply(0, 0, 0, 1, 0, 1);
    check("R5", "zero dst A", fwd_a, 2'b00);
    check("R5", "zero dst B", fwd_b, 2'b00);
    apply(17, 17, 17, 0, 17, 0);
    check("R6", "no write A", fwd_a, 2'b00);
    check("R6", "no write B", fwd_b, 2'b00);
    apply(9, 20, 9, 1, 20, 1);
    check("R2", "split A", fwd_a, 2'b10);
    check("R4", "split B", fwd_b, 2'b01);

    // exhaustive sweep over registers 0..3
    for (int f = 0; f < 4; f++)
      for (int rs = 0; rs < 4; rs++)
        for (int rt = 0; rt < 4; rt++)
          for (int md = 0; md < 4; md++)
            for (int wd = 0; wd < 4; wd++) begin
              apply(rs[4:0], rt[4:0], md[4:0], f[0], wd[4:0], f[1]);
              check_both();
            end

    // random full-width cases plus independence probes
    for (int k = 0; k < 400; k++) begin
      logic [1:0] a_before, b_before;
      logic [4:0] r0, r1, r2, r3;
      r0 = 5'($urandom_range(0, 31)); r1 = 5'($urandom_range(0, 31));
      r2 = 5'($urandom_range(0, 31)); r3 = 5'($urandom_range(0, 31));
      if (k % 3 == 0) r2 = r0;
      if (k % 5 == 0) r3 = r1;
      apply(r0, r1, r2, 1'($urandom_range(0, 1)), r3, 1'($urandom_range(0, 1)));
      check_both();
      a_before = fwd_a;
      b_before = fwd_b;
      apply(ex_rs, 5'($urandom_range(0, 31)), mem_dst, mem_wr, wb_dst, wb_wr);
      check("R8", "A held when rt moves", fwd_a, a_before);
      check("R3", "B after rt moves", fwd_b, ref_sel(ex_rt));
      apply(5'($urandom_range(0, 31)), ex_rt, mem_dst, mem_wr, wb_dst, wb_wr);
      b_before = ref_sel(ex_rt);
      check("R8", "B held when rs moves", fwd_b, b_before);
      check("R2", "A after rs moves", fwd_a, ref_sel(ex_rs));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule